// File: doc/BRIEF.md
# Two-Stage Watchdog Countdown Core

This core guards a system against a stalled processor by counting down in two back-to-back stages. Software arms it by raising the enable control; from then on it must issue keep-alive strobes often enough that the first stage never runs out. If the first stage does run out, the core emits a warning pulse (an ordinary interrupt or a system-management interrupt, chosen by a 2-bit type) and moves straight into the second stage. If the second stage also runs out, the core either asks for a system reset and records the event in a sticky flag, or (with reboot disabled) restarts or halts as the free-run control dictates.

Each stage length comes from its own 20-bit preload. The preload is scaled by a left shift: a large shift in the default slow mode, a small one in fast mode. The register file that holds the controls, as well as the bus decoding and the unlock sequence, sits outside this core. The sticky timeout flag has its own power-up reset, so a system reset that the core itself requested does not erase the evidence.

Top module: `wdog_two_stage`

## Requirements
- R1: After power-up reset and block reset, `irq_o`, `smi_o`, `rst_req_o` and `prev_timeout_o` are all 0, and no pulse appears while `enable` stays 0.
- R2: A stage loads L = preload << SLOW_SHIFT when `fast_scale`=0, or preload << FAST_SHIFT when `fast_scale`=1. Counting the edge that first samples `enable`=1 as edge 1, the stage-1 pulse is visible after edge L1+2. The stage-2 expiry result is visible L2+1 edges after the stage-1 pulse edge. A preload of 0 gives a one-tick stage.
- R3: At stage-1 expiry, `int_type`=0 gives a pulse on `irq_o`, `int_type`=2 a pulse on `smi_o`, and `int_type`=1 or 3 gives neither. Stage 2 follows in every case.
- R4: A 0-to-1 change of `enable` starts stage 1 from `preload1`. While `enable` is 0, counting is stopped and no pulse appears.
- R5: A `keepalive` strobe sampled with `enable`=1 restarts stage 1 from `preload1`. The next stage-1 pulse is visible L1+1 edges after the strobe edge. A strobe sampled with `enable`=0 has no effect.
- R6: Stage-2 expiry with `reboot_en`=1 pulses `rst_req_o` and sets `prev_timeout_o` in the same cycle. Counting then stops, and keep-alive strobes are ignored until `enable` is taken to 0 and back to 1.
- R7: Stage-2 expiry with `reboot_en`=0 and `free_run`=1 gives no reset request and restarts stage 1 from `preload1`.
- R8: Stage-2 expiry with `reboot_en`=0 and `free_run`=0 halts the count with no further pulses. A later keep-alive strobe while enabled starts stage 1 again.
- R9: `prev_timeout_o` keeps its value through the block reset `rst_n`. It is cleared only by a `flag_clr` strobe or by the power-up reset `por_n`.
- R10: `irq_o`, `smi_o` and `rst_req_o` are single-cycle pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock, one tick per cycle |
| rst_n | input | 1 | Block reset, active low, asynchronous assert |
| por_n | input | 1 | Power-up reset for the sticky flag, active low |
| enable | input | 1 | Watchdog armed; a rising edge starts stage 1 |
| free_run | input | 1 | Restart stage 1 after a stage-2 expiry that does not reboot |
| reboot_en | input | 1 | Stage-2 expiry requests a reset |
| fast_scale | input | 1 | 1 selects the small prescale shift |
| int_type | input | 2 | Stage-1 signal: 0 irq, 2 smi, 1/3 none |
| preload1 | input | PRELOAD_W | Stage-1 preload |
| preload2 | input | PRELOAD_W | Stage-2 preload |
| keepalive | input | 1 | Restart strobe |
| flag_clr | input | 1 | Clear strobe for the timeout flag |
| irq_o | output | 1 | Ordinary interrupt pulse |
| smi_o | output | 1 | System-management interrupt pulse |
| rst_req_o | output | 1 | Reset request pulse |
| prev_timeout_o | output | 1 | Sticky flag: a watchdog reset was requested |

## Verification
The embedded properties watch, on every cycle, that the outputs are single-cycle pulses that never coincide, and that a reset request comes with the flag set. They also check that the flag holds without a clear strobe, that dropping enable stops the count, and that an enable edge or a keep-alive strobe reloads stage 1 from its preload. The exact stage lengths under both scales and the zero preload, the choice of interrupt type, and the free-run restart versus the halt all need the bench's timed scenarios. So do the lock-out after a reboot expiry and the flag surviving a block reset.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    ITYPE_IRQ  = 2'd0,
    ITYPE_RSVD = 2'd1,
    ITYPE_SMI  = 2'd2,
    ITYPE_NONE = 2'd3
  } itype_e;

  typedef enum logic {
    STG_ONE = 1'b0,
    STG_TWO = 1'b1
  } stage_e;
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/wdog_load_calc.sv
module wdog_load_calc #(
  parameter int PRELOAD_W  = 20,
  parameter int SLOW_SHIFT = 15,
  parameter int FAST_SHIFT = 5,
  localparam int CNT_W     = PRELOAD_W + SLOW_SHIFT
) (
  input  logic [PRELOAD_W-1:0] preload1,
  input  logic [PRELOAD_W-1:0] preload2,
  input  logic                 fast_scale,
  output logic [CNT_W-1:0]     load1,
  output logic [CNT_W-1:0]     load2
);
  logic [1:0][PRELOAD_W-1:0] pre_arr;
  logic [1:0][CNT_W-1:0]     load_arr;

  assign pre_arr[0] = preload1;
  assign pre_arr[1] = preload2;

  for (genvar g = 0; g < 2; g++) begin : g_stage
    logic [CNT_W-1:0] ext;
    assign ext = CNT_W'(pre_arr[g]);
    always_comb begin
      if (fast_scale) load_arr[g] = ext << FAST_SHIFT;
      else            load_arr[g] = ext << SLOW_SHIFT;
    end
  end

  assign load1 = load_arr[0];
  assign load2 = load_arr[1];
endmodule

// File: rtl/wdog_stage_ctrl.sv
module wdog_stage_ctrl
  import wdog_pkg::*;
#(
  parameter int CNT_W = 35
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             keepalive,
  input  logic             free_run,
  input  logic             reboot_en,
  input  logic [CNT_W-1:0] load1,
  input  logic [CNT_W-1:0] load2,
  output logic             s1_exp,
  output logic             s2_exp
);
  logic             en_q, tripped_q, run_q;
  stage_e           stage_q;
  logic [CNT_W-1:0] cnt_q;

  logic             tripped_d, run_d;
  stage_e           stage_d;
  logic [CNT_W-1:0] cnt_d;
  logic             en_rise, en_eff, restart, at_zero, tick_exp, cnt_ce;

  assign en_rise  = enable & ~en_q;
  assign en_eff   = enable & ~tripped_q;
  assign restart  = en_eff & (en_rise | keepalive);
  assign at_zero  = run_q & (cnt_q == '0);
  assign tick_exp = en_eff & ~restart & at_zero;
  assign s1_exp   = tick_exp & (stage_q == STG_ONE);
  assign s2_exp   = tick_exp & (stage_q == STG_TWO);
  assign cnt_ce   = restart | run_q;

  always_comb begin
    tripped_d = enable & (tripped_q | (s2_exp & reboot_en));
    run_d     = run_q;
    stage_d   = stage_q;
    cnt_d     = cnt_q;
    if (!en_eff) begin
      run_d = 1'b0;
    end else if (restart) begin
      run_d   = 1'b1;
      stage_d = STG_ONE;
      cnt_d   = load1;
    end else if (s1_exp) begin
      stage_d = STG_TWO;
      cnt_d   = load2;
    end else if (s2_exp) begin
      if (!reboot_en && free_run) begin
        stage_d = STG_ONE;
        cnt_d   = load1;
      end else begin
        run_d = 1'b0;
      end
    end else if (run_q) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      tripped_q <= 1'b0;
      run_q     <= 1'b0;
      stage_q   <= STG_ONE;
    end else begin
      en_q      <= enable;
      tripped_q <= tripped_d;
      run_q     <= run_d;
      stage_q   <= stage_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  // R4: dropping enable halts the count on the next edge
  a_r4_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !run_q);

  // R4: an enable edge starts stage 1 from its preload
  a_r4_start: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !en_q) |=> (run_q && stage_q == STG_ONE && cnt_q == $past(load1)));

  // R5: an accepted keep-alive reloads stage 1
  a_r5_kick: assert property (@(posedge clk) disable iff (!rst_n)
    (keepalive && enable && !tripped_q) |=> (stage_q == STG_ONE && cnt_q == $past(load1)));

  // R6: a rebooting expiry stops counting
  a_r6_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_exp && reboot_en) |=> !run_q);
endmodule

// File: rtl/wdog_events.sv
module wdog_events
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_n,
  input  logic       s1_exp,
  input  logic       s2_exp,
  input  logic       reboot_en,
  input  logic [1:0] int_type,
  input  logic       flag_clr,
  output logic       irq_o,
  output logic       smi_o,
  output logic       rst_req_o,
  output logic       prev_timeout_o
);
  logic irq_d, smi_d, rst_d, flag_d, flag_ce;

  assign irq_d   = s1_exp & (itype_e'(int_type) == ITYPE_IRQ);
  assign smi_d   = s1_exp & (itype_e'(int_type) == ITYPE_SMI);
  assign rst_d   = s2_exp & reboot_en;
  assign flag_ce = rst_d | flag_clr;
  assign flag_d  = rst_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o     <= 1'b0;
      smi_o     <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      irq_o     <= irq_d;
      smi_o     <= smi_d;
      rst_req_o <= rst_d;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       prev_timeout_o <= 1'b0;
    else if (flag_ce) prev_timeout_o <= flag_d;
  end

  a_r10_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  a_r10_smi_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    smi_o |=> !smi_o);
  a_r10_rst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_o, smi_o, rst_req_o}));
  a_r6_flag_with_req: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    rst_req_o |-> prev_timeout_o);
  a_r9_sticky: assert property (@(posedge clk) disable iff (!por_n)
    (prev_timeout_o && !flag_clr) |=> prev_timeout_o);
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
  parameter int PRELOAD_W  = 20,
  parameter int SLOW_SHIFT = 15,
  parameter int FAST_SHIFT = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 por_n,
  input  logic                 enable,
  input  logic                 free_run,
  input  logic                 reboot_en,
  input  logic                 fast_scale,
  input  logic [1:0]           int_type,
  input  logic [PRELOAD_W-1:0] preload1,
  input  logic [PRELOAD_W-1:0] preload2,
  input  logic                 keepalive,
  input  logic                 flag_clr,
  output logic                 irq_o,
  output logic                 smi_o,
  output logic                 rst_req_o,
  output logic                 prev_timeout_o
);
  localparam int CNT_W = PRELOAD_W + SLOW_SHIFT;

  logic [1:0]       rst_raw, rst_sync;
  logic             blk_rst_n, pwr_rst_n;
  logic [CNT_W-1:0] load1, load2;
  logic             s1_exp, s2_exp;

  assign rst_raw = {por_n, rst_n};

  for (genvar g = 0; g < 2; g++) begin : g_rsync
    wdog_rst_sync u_sync (
      .clk    (clk),
      .arst_n (rst_raw[g]),
      .srst_n (rst_sync[g])
    );
  end

  assign blk_rst_n = rst_sync[0];
  assign pwr_rst_n = rst_sync[1];

  wdog_load_calc #(
    .PRELOAD_W  (PRELOAD_W),
    .SLOW_SHIFT (SLOW_SHIFT),
    .FAST_SHIFT (FAST_SHIFT)
  ) u_load (
    .preload1   (preload1),
    .preload2   (preload2),
    .fast_scale (fast_scale),
    .load1      (load1),
    .load2      (load2)
  );

  wdog_stage_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (blk_rst_n),
    .enable    (enable),
    .keepalive (keepalive),
    .free_run  (free_run),
    .reboot_en (reboot_en),
    .load1     (load1),
    .load2     (load2),
    .s1_exp    (s1_exp),
    .s2_exp    (s2_exp)
  );

  wdog_events u_evt (
    .clk            (clk),
    .rst_n          (blk_rst_n),
    .por_n          (pwr_rst_n),
    .s1_exp         (s1_exp),
    .s2_exp         (s2_exp),
    .reboot_en      (reboot_en),
    .int_type       (int_type),
    .flag_clr       (flag_clr),
    .irq_o          (irq_o),
    .smi_o          (smi_o),
    .rst_req_o      (rst_req_o),
    .prev_timeout_o (prev_timeout_o)
  );
endmodule

// File: tb/wdog_two_stage_tb_top.sv
module wdog_two_stage_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PW  = 20;
  localparam int SS  = 4;
  localparam int FS  = 1;
  localparam int NV  = 5;
  localparam int WDOG_LIMIT = 150000;

  // vector: {fast_scale, int_type[1:0], preload1[3:0], preload2[3:0]}
  localparam logic [10:0] VEC [NV] = '{
    {1'b0, 2'd0, 4'd2, 4'd1},
    {1'b1, 2'd2, 4'd5, 4'd3},
    {1'b1, 2'd3, 4'd0, 4'd0},
    {1'b0, 2'd1, 4'd1, 4'd0},
    {1'b1, 2'd0, 4'd0, 4'd2}
  };

  logic clk = 1'b0;
  logic rst_n, por_n, enable, free_run, reboot_en, fast_scale;
  logic [1:0] int_type;
  logic [PW-1:0] preload1, preload2;
  logic keepalive, flag_clr;
  logic irq_o, smi_o, rst_req_o, prev_timeout_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_two_stage #(.PRELOAD_W(PW), .SLOW_SHIFT(SS), .FAST_SHIFT(FS)) dut_i (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .enable(enable),
    .free_run(free_run), .reboot_en(reboot_en), .fast_scale(fast_scale),
    .int_type(int_type), .preload1(preload1), .preload2(preload2),
    .keepalive(keepalive), .flag_clr(flag_clr), .irq_o(irq_o),
    .smi_o(smi_o), .rst_req_o(rst_req_o), .prev_timeout_o(prev_timeout_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG_LIMIT && !done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // kind: 0 none, 1 irq, 2 smi, 3 reset request
  task automatic wait_event(input int max, output int n, output int kind);
    n = 0;
    kind = 0;
    while (kind == 0 && n < max) begin
      tick();
      n++;
      if (irq_o)          kind = 1;
      else if (smi_o)     kind = 2;
      else if (rst_req_o) kind = 3;
    end
  endtask

  function automatic int ld(input bit fast, input int p);
    return fast ? (p << FS) : (p << SS);
  endfunction

  task automatic pulse_kick();
    keepalive = 1'b1;
    tick();
    keepalive = 1'b0;
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1;
    tick();
    flag_clr = 1'b0;
  endtask

  initial begin
    int n, k, l1, l2, ek, en;
    rst_n = 1'b0; por_n = 1'b0; enable = 1'b0; free_run = 1'b0;
    reboot_en = 1'b1; fast_scale = 1'b0; int_type = 2'd0;
    preload1 = '0; preload2 = '0; keepalive = 1'b0; flag_clr = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1; por_n = 1'b1;
    repeat (4) tick();

    // R1: reset state
    check({irq_o, smi_o, rst_req_o, prev_timeout_o} == 4'b0, "R1 reset outputs",
          {irq_o, smi_o, rst_req_o, prev_timeout_o}, 0);
    wait_event(40, n, k);
    check(k == 0, "R1 idle while disabled", k, 0);

    // table walk: R2, R3, R6, R9, R10
    for (int v = 0; v < NV; v++) begin
      fast_scale = VEC[v][10];
      int_type   = VEC[v][9:8];
      preload1   = PW'(VEC[v][7:4]);
      preload2   = PW'(VEC[v][3:0]);
      reboot_en  = 1'b1;
      free_run   = 1'b0;
      enable     = 1'b0;
      repeat (2) tick();
      l1 = ld(fast_scale, int'(VEC[v][7:4]));
      l2 = ld(fast_scale, int'(VEC[v][3:0]));
      if (int_type == 2'd0)      begin ek = 1; en = l1 + 2; end
      else if (int_type == 2'd2) begin ek = 2; en = l1 + 2; end
      else                       begin ek = 3; en = l1 + l2 + 3; end
      enable = 1'b1;
      wait_event(400, n, k);
      check(k == ek, "R3 stage-1 signal kind", k, ek);
      check(n == en, "R2 first event timing", n, en);
      if (ek != 3) begin
        wait_event(400, n, k);
        check(!irq_o || k == 3, "R10 pulse width", n, 0);
        check(k == 3, "R3 stage 2 follows", k, 3);
        check(n == l2 + 1, "R2 stage-2 length", n, l2 + 1);
      end
      check(prev_timeout_o == 1'b1, "R6 flag set on reboot", prev_timeout_o, 1);
      tick();
      check(rst_req_o == 1'b0, "R10 reset request pulse width", rst_req_o, 0);
      enable = 1'b0;
      tick();
      pulse_clr();
      check(prev_timeout_o == 1'b0, "R9 clear strobe", prev_timeout_o, 0);
    end

    // R5: keep-alive restarts stage 1
    fast_scale = 1'b1; int_type = 2'd0; preload1 = PW'(5); preload2 = PW'(1);
    reboot_en = 1'b0; free_run = 1'b0;
    l1 = 10; l2 = 2;
    enable = 1'b1;
    repeat (6) tick();
    pulse_kick();
    wait_event(100, n, k);
    check(k == 1, "R5 kick then irq", k, 1);
    check(n == l1 + 1, "R5 kick restart timing", n, l1 + 1);

    // R8: halt without free-run, then keep-alive restarts
    wait_event(100, n, k);
    check(k == 0, "R8 halted, no events", k, 0);
    check(prev_timeout_o == 1'b0, "R8 no flag without reboot", prev_timeout_o, 0);
    pulse_kick();
    wait_event(100, n, k);
    check(k == 1 && n == l1 + 1, "R8 kick restarts after halt", n, l1 + 1);

    // R7: free-run restart
    free_run = 1'b1;
    wait_event(100, n, k);
    check(k == 1, "R7 free-run gives irq, not reset", k, 1);
    check(n == l2 + l1 + 2, "R7 free-run restart timing", n, l2 + l1 + 2);

    // R4: disable stops, R5 kick while disabled ignored
    enable = 1'b0;
    wait_event(60, n, k);
    check(k == 0, "R4 no events while disabled", k, 0);
    pulse_kick();
    wait_event(60, n, k);
    check(k == 0, "R5 kick ignored while disabled", k, 0);

    // R6: lock-out after reboot expiry
    free_run = 1'b0; reboot_en = 1'b1; int_type = 2'd3;
    preload1 = '0; preload2 = '0;
    enable = 1'b1;
    wait_event(50, n, k);
    check(k == 3 && n == 3, "R6 zero preloads reboot", n, 3);
    pulse_kick();
    wait_event(60, n, k);
    check(k == 0, "R6 kick ignored after reboot", k, 0);

    // R9: flag survives block reset, cleared by power-up reset
    enable = 1'b0;
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    check(prev_timeout_o == 1'b1, "R9 flag survives rst_n", prev_timeout_o, 1);
    por_n = 1'b0;
    tick();
    por_n = 1'b1;
    repeat (4) tick();
    check(prev_timeout_o == 1'b0, "R9 por_n clears flag", prev_timeout_o, 0);

    // R4: re-arm after lock-out with a fresh enable edge
    int_type = 2'd2; fast_scale = 1'b1; preload1 = PW'(2); preload2 = PW'(4);
    enable = 1'b1;
    wait_event(60, n, k);
    check(k == 2 && n == 6, "R4 enable edge restarts", n, 6);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule